// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Grouped External Interrupts

This block is one general-purpose I/O port of eight pins on a small register bus. Software picks, pin by pin, whether a pin is driven from an internal output latch or observed as an input. An option bit per pin works only while that pin is an input. It turns on the pad pull-up, and it also makes the pin a source for the external interrupt group that the pin belongs to. The pads themselves are outside the block: the port drives output-enable, output-value and pull-up-enable lines and receives the raw pad levels.

The pins form two interrupt groups. Every enabled input pin in a group is merged by a logical AND into one group signal. A per-group detector, set by a two-bit sensitivity field, looks at that group signal. When it sees an event it sets a pending latch, and that latch drives the group's request line. The interrupt controller clears the latch by pulsing the group's acknowledge input. Software can also clear it by writing a different sensitivity value for that group.

Raw pad levels pass through a two-flop synchronizer before any read or detection uses them. Every bus read returns its data one clock after the address is presented.

Top module: `gpio_eint_port`

## Requirements
- R1: While reset is high and right after it, the data, direction, option and sensitivity registers are all zero. Output enables, output values, pull-up enables, interrupt requests and read data are all zero.
- R2: Register select 1 is the direction register. A 1 makes the pin an output, so its pad_oe bit is 1. pad_out always carries the data latch.
- R3: Register select 0 is the data register. Reading it returns the latch bit for output pins and the synchronized pad level for input pins. Read data shows up on bus_rdata one clock after the address.
- R4: A write to the data register changes only the latch. On pins in input mode the pad is not driven (pad_oe stays 0), and the new value reaches the pad once the pin becomes an output.
- R5: Register select 2 is the option register. pad_pu for a pin is 1 exactly when that pin is an input and its option bit is 1.
- R6: Pins 0 to 3 feed group 0 and pins 4 to 7 feed group 1. Only pins that are inputs with their option bit set take part, and they are ANDed. A low enabled pin masks its group, and disabling that pin removes the mask.
- R7: Sensitivity code 00 requests on a low group level. While the level stays low, the request is set again after every acknowledge.
- R8: Code 01 requests only on a rising group edge, code 10 only on a falling edge, and code 11 on either edge.
- R9: A pulse on irq_ack[v] clears pending request v. If a new event on that group occurs in the same cycle, the request stays set.
- R10: A write to register select 3 that changes group v's field clears request v, and this clear wins over an event in that cycle. Rewriting an unchanged field leaves the request as it is.
- R11: A pad change that makes an event shows up on irq_req on the third rising clock edge after the change.
- R12: Register select 3 holds group 0's code in bits 1:0 and group 1's code in bits 3:2. Bits 7:4 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad levels |
| pad_out | output | 8 | Output value to pads |
| pad_oe | output | 8 | Output enable to pads |
| pad_pu | output | 8 | Pull-up enable to pads |
| irq_ack | input | 2 | Per-group request acknowledge |
| irq_req | output | 2 | Per-group pending request |

## Verification
Two functions can land on the same edge. The first pair is an acknowledge and a fresh event in the same group. The bench times a pad edge so that its detection cycle, two clocks after the synchronizer stages, lines up with a one-cycle acknowledge pulse, and it expects the request to stay set. A continuously low group in level mode causes the same collision on every acknowledge. The second pair is a sensitivity write and a pending level request. There the bench expects the request to drop and stay low, and it expects rewrites that leave the field unchanged to keep the request set.

// File: rtl/gpio_eint_pkg.sv
package gpio_eint_pkg;
  localparam int ADDR_W  = 2;
  localparam int SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_OPT   = 2'd2,
    SEL_SENSE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_eint_sync.sv
module gpio_eint_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_eint_regs.sv
module gpio_eint_regs
  import gpio_eint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int NUM_VEC  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_PINS-1:0]       wdata,
  input  logic                      we,
  input  logic [NUM_PINS-1:0]       pin_sync,
  output logic [NUM_PINS-1:0]       data_q,
  output logic [NUM_PINS-1:0]       dir_q,
  output logic [NUM_PINS-1:0]       opt_q,
  output logic [NUM_PINS-1:0]       pu_q,
  output logic [NUM_VEC*SENSE_W-1:0] sense_q,
  output logic [NUM_VEC-1:0]        sense_chg,
  output logic [NUM_PINS-1:0]       rdata
);
  localparam int SW = NUM_VEC * SENSE_W;

  reg_sel_e sel;
  logic wr_data, wr_dir, wr_opt, wr_sense;
  logic [NUM_PINS-1:0] dir_nxt, opt_nxt, rd_mux;

  assign sel      = reg_sel_e'(addr);
  assign wr_data  = we && (sel == SEL_DATA);
  assign wr_dir   = we && (sel == SEL_DIR);
  assign wr_opt   = we && (sel == SEL_OPT);
  assign wr_sense = we && (sel == SEL_SENSE);

  assign dir_nxt = wr_dir ? wdata : dir_q;
  assign opt_nxt = wr_opt ? wdata : opt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      opt_q   <= '0;
      pu_q    <= '0;
      sense_q <= '0;
    end else begin
      if (wr_data)  data_q  <= wdata;
      if (wr_sense) sense_q <= wdata[SW-1:0];
      dir_q <= dir_nxt;
      opt_q <= opt_nxt;
      pu_q  <= ~dir_nxt & opt_nxt;
    end
  end

  // A group field counts as rewritten only when its value changes
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chg
    assign sense_chg[v] = wr_sense &&
      (wdata[v*SENSE_W +: SENSE_W] != sense_q[v*SENSE_W +: SENSE_W]);
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DATA:  rd_mux = (dir_q & data_q) | (~dir_q & pin_sync);
      SEL_DIR:   rd_mux = dir_q;
      SEL_OPT:   rd_mux = opt_q;
      SEL_SENSE: rd_mux[SW-1:0] = sense_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  a_r2_dir_loads: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> dir_q == $past(wdata));
  a_r4_data_write_keeps_dir: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !wr_dir) |=> $stable(dir_q));
  a_r5_pullup_inputs_only: assert property (@(posedge clk) disable iff (rst)
    (pu_q & dir_q) == '0);
  a_r12_sense_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(sel == SEL_SENSE) |-> rdata[NUM_PINS-1:SW] == '0);
endmodule

// File: rtl/gpio_eint_vec.sv
module gpio_eint_vec
  import gpio_eint_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   pins,
  input  logic [WIDTH-1:0]   en,
  input  logic [SENSE_W-1:0] sense,
  input  logic               sense_chg,
  input  logic               ack,
  output logic               pend
);
  logic comb_now, comb_prev, rise, fall, hit;

  // Disabled pins read as high so they never mask the group
  assign comb_now = &(pins | ~en);
  assign rise     = comb_now & ~comb_prev;
  assign fall     = ~comb_now & comb_prev;

  always_comb begin
    case (sense_e'(sense))
      SENSE_LOW:  hit = ~comb_now;
      SENSE_RISE: hit = rise;
      SENSE_FALL: hit = fall;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      comb_prev <= 1'b1;
      pend      <= 1'b0;
    end else begin
      comb_prev <= comb_now;
      if (sense_chg) pend <= 1'b0;
      else if (hit)  pend <= 1'b1;
      else if (ack)  pend <= 1'b0;
    end
  end

  a_r10_sense_change_clears: assert property (@(posedge clk) disable iff (rst)
    sense_chg |=> !pend);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !hit && !sense_chg) |=> !pend);
  a_r9_event_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (hit && !sense_chg) |=> pend);
  a_r8_no_set_without_event: assert property (@(posedge clk) disable iff (rst)
    (!pend && !hit) |=> !pend);
endmodule

// File: rtl/gpio_eint_port.sv
module gpio_eint_port
  import gpio_eint_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int NUM_VEC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  input  logic                bus_we,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu,
  input  logic [NUM_VEC-1:0]  irq_ack,
  output logic [NUM_VEC-1:0]  irq_req
);
  localparam int PINS_PER_VEC = NUM_PINS / NUM_VEC;

  logic [NUM_PINS-1:0]        pin_sync, data_q, dir_q, opt_q, pu_q, irq_en;
  logic [NUM_VEC*SENSE_W-1:0] sense_q;
  logic [NUM_VEC-1:0]         sense_chg;

  gpio_eint_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  gpio_eint_regs #(.NUM_PINS(NUM_PINS), .NUM_VEC(NUM_VEC)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .we        (bus_we),
    .pin_sync  (pin_sync),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .opt_q     (opt_q),
    .pu_q      (pu_q),
    .sense_q   (sense_q),
    .sense_chg (sense_chg),
    .rdata     (bus_rdata)
  );

  assign irq_en = ~dir_q & opt_q;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    gpio_eint_vec #(.WIDTH(PINS_PER_VEC)) u_vec (
      .clk       (clk),
      .rst       (rst),
      .pins      (pin_sync[v*PINS_PER_VEC +: PINS_PER_VEC]),
      .en        (irq_en[v*PINS_PER_VEC +: PINS_PER_VEC]),
      .sense     (sense_q[v*SENSE_W +: SENSE_W]),
      .sense_chg (sense_chg[v]),
      .ack       (irq_ack[v]),
      .pend      (irq_req[v])
    );
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign pad_pu  = pu_q;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (irq_req == '0 && pad_oe == '0 && pad_pu == '0));
endmodule

// File: tb/gpio_eint_port_test.sv
`timescale 1ns/1ps
module gpio_eint_port_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in, pad_out, pad_oe, pad_pu;
  logic [1:0] irq_ack, irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gpio_eint_port uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // row: {select, write data, readback, pad_oe, pad_pu, pad_out}, pads held at A5
  localparam logic [47:0] TBL [9] = '{
    {8'd1, 8'hF0, 8'hF0, 8'hF0, 8'h00, 8'h00},
    {8'd0, 8'h3C, 8'h35, 8'hF0, 8'h00, 8'h3C},
    {8'd2, 8'h0F, 8'h0F, 8'hF0, 8'h0F, 8'h3C},
    {8'd1, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h3C},
    {8'd0, 8'hFF, 8'hA5, 8'h00, 8'h0F, 8'hFF},
    {8'd1, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF},
    {8'd3, 8'hFB, 8'h0B, 8'hFF, 8'h00, 8'hFF},
    {8'd1, 8'h5A, 8'h5A, 8'h5A, 8'h05, 8'hFF},
    {8'd0, 8'h00, 8'hA5, 8'h5A, 8'h05, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic ack(input logic [1:0] m);
    @(negedge clk);
    irq_ack = m;
    @(negedge clk);
    irq_ack = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    pad_in = 8'hA5; irq_ack = 2'b00;
    tick(4);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 irq", {6'b0, irq_req}, 8'h00);
    rd(2'd1, v); chk("R1 dir reg", v, 8'h00);
    rd(2'd2, v); chk("R1 opt reg", v, 8'h00);
    rd(2'd3, v); chk("R1 sense reg", v, 8'h00);

    for (int i = 0; i < 9; i++) begin
      wr(TBL[i][41:40], TBL[i][39:32]);
      rd(TBL[i][41:40], v);
      chk($sformatf("R3 R12 readback row %0d", i), v, TBL[i][31:24]);
      chk($sformatf("R2 pad_oe row %0d", i), pad_oe, TBL[i][23:16]);
      chk($sformatf("R5 pad_pu row %0d", i), pad_pu, TBL[i][15:8]);
      chk($sformatf("R4 pad_out row %0d", i), pad_out, TBL[i][7:0]);
    end

    // Interrupt setup: all inputs, all enabled, both groups rising
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    pad_in = 8'hFF;
    wr(2'd3, 8'h05);
    tick(4);
    ack(2'b11);
    tick(2);
    chk("R8 idle after setup", {6'b0, irq_req}, 8'h00);

    @(negedge clk); pad_in[2] = 1'b0;
    tick(4);
    chk("R8 fall ignored in rise mode", {6'b0, irq_req}, 8'h00);
    @(negedge clk); pad_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R11 not yet after two edges", {6'b0, irq_req}, 8'h00);
    @(negedge clk);
    chk("R11 R6 request on third edge, group 0", {6'b0, irq_req}, 8'h01);
    ack(2'b01);
    chk("R9 ack clears", {6'b0, irq_req}, 8'h00);

    // Pin 4 held low masks group 1
    @(negedge clk); pad_in[4] = 1'b0;
    tick(4);
    pad_in[5] = 1'b0; tick(4);
    pad_in[5] = 1'b1; tick(4);
    chk("R6 low pin masks group", {6'b0, irq_req}, 8'h00);
    wr(2'd2, 8'hEF);
    tick(3);
    chk("R6 mask removed gives rise", {6'b0, irq_req}, 8'h02);
    ack(2'b10);
    pad_in[4] = 1'b1;
    wr(2'd2, 8'hFF);
    tick(3);
    chk("R6 group 1 quiet", {6'b0, irq_req}, 8'h00);

    // Output-mode pin does not feed its group
    wr(2'd1, 8'h01);
    pad_in[0] = 1'b0; tick(5);
    pad_in[0] = 1'b1; tick(5);
    chk("R6 output pin excluded", {6'b0, irq_req}, 8'h00);
    wr(2'd1, 8'h00);
    tick(3);

    // Falling only on group 0
    wr(2'd3, 8'h06);
    tick(2);
    pad_in[0] = 1'b0; tick(4);
    chk("R8 falling detected", {6'b0, irq_req}, 8'h01);
    ack(2'b01);
    pad_in[0] = 1'b1; tick(4);
    chk("R8 rise ignored in fall mode", {6'b0, irq_req}, 8'h00);

    // Both edges
    wr(2'd3, 8'h07);
    pad_in[0] = 1'b0; tick(4);
    chk("R8 both mode falling", {6'b0, irq_req}, 8'h01);
    ack(2'b01);
    pad_in[0] = 1'b1; tick(4);
    chk("R8 both mode rising", {6'b0, irq_req}, 8'h01);
    ack(2'b01);
    chk("R8 both mode acked", {6'b0, irq_req}, 8'h00);

    // Level low
    wr(2'd3, 8'h04);
    pad_in[0] = 1'b0; tick(4);
    chk("R7 low level requests", {6'b0, irq_req}, 8'h01);
    ack(2'b01);
    chk("R7 R9 level reasserts over ack", {6'b0, irq_req}, 8'h01);
    pad_in[0] = 1'b1; tick(4);
    chk("R7 latch holds after release", {6'b0, irq_req}, 8'h01);
    ack(2'b01);
    chk("R7 cleared once high", {6'b0, irq_req}, 8'h00);

    // Sensitivity write clears pending level request
    pad_in[0] = 1'b0; tick(4);
    wr(2'd3, 8'h07);
    chk("R10 change clears", {6'b0, irq_req}, 8'h00);
    tick(3);
    chk("R10 stays clear", {6'b0, irq_req}, 8'h00);
    pad_in[0] = 1'b1; tick(4);
    wr(2'd3, 8'h07);
    chk("R10 same value keeps request", {6'b0, irq_req}, 8'h01);
    wr(2'd3, 8'h03);
    chk("R10 other field change keeps request", {6'b0, irq_req}, 8'h01);
    wr(2'd3, 8'h02);
    chk("R10 field change clears", {6'b0, irq_req}, 8'h00);

    // Ack and falling event in the same cycle
    pad_in[0] = 1'b0; tick(4);
    pad_in[0] = 1'b1; tick(4);
    chk("R9 pending before collision", {6'b0, irq_req}, 8'h01);
    @(negedge clk); pad_in[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); irq_ack = 2'b01;
    @(negedge clk); irq_ack = 2'b00;
    chk("R9 event wins over ack", {6'b0, irq_req}, 8'h01);
    ack(2'b01);
    chk("R9 plain ack clears", {6'b0, irq_req}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule